// File: doc/BRIEF.md
# Programmable Read Strobe Generator

This block drives the active-low read strobe for one basic read cycle on an external bus. It also gives a one-tick data-capture pulse and a cycle-done pulse. Each of the address areas has its own timing bit in a control register. When the bit for the area being read is clear, the strobe stays low until the last bus state ends. When the bit is set, the strobe releases half a bus state sooner, and the capture point moves with it.

The block runs on a tick clock at twice the bus-state rate. Each bus state is two ticks: the first half is the high clock phase and the second half is the low clock phase. A request carries an area number. A cycle-length select picks a two-state cycle (T1, T2) or a three-state cycle (T1 to T3). The area's timing bit and the cycle length are latched when the cycle starts. A request is accepted in idle, or in the final tick of a cycle. In the final tick the next cycle follows without a gap.

Top module: `rsg_read_strobe`

## Requirements
- R1: After reset the control register reads 8'h00, `rd_n_o` is 1, and `cap_o` and `done_o` are 0.
- R2: A write with `reg_we_i` high loads `reg_wdata_i` into the register. The new value shows on `reg_rdata_o` in the following tick. Bit n belongs to area n. Without a write the register holds its value.
- R3: Ticks of a cycle are numbered from 0, where tick 0 is the tick after the edge that accepted the request. `rd_n_o` is 1 in tick 0 (first half of T1) and goes to 0 in tick 1 (second half of T1).
- R4: With the latched area bit at 0, `rd_n_o` stays 0 through tick 2N-1, where N is the number of states. It is 1 again in the tick after that.
- R5: With the latched area bit at 1, `rd_n_o` is 0 only through tick 2N-2, which is one half-state earlier. It is 1 in tick 2N-1.
- R6: `cap_o` pulses for exactly one tick in each cycle, in the last tick where `rd_n_o` is 0 (tick 2N-1, or tick 2N-2 for an early area).
- R7: `done_o` pulses for exactly one tick in each cycle, in tick 2N-1.
- R8: `three_state_i` sampled at the accepting edge selects N: 1 gives N=3, 0 gives N=2.
- R9: The area number, its timing bit and the length select are all latched at the accepting edge. Changing `area_i`, `three_state_i` or the register during a cycle does not alter that cycle.
- R10: A request in any tick of a cycle other than its final tick is ignored. The cycle ends normally and the block returns to idle with `rd_n_o` high.
- R11: A request held in the final tick (`done_o` high) starts the next cycle at once. That cycle's tick 0 is the tick right after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, two ticks per bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start-read request |
| area_i | input | 3 | Area number of the request |
| three_state_i | input | 1 | 1 selects a three-state cycle, 0 a two-state cycle |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data, bit n for area n |
| reg_rdata_o | output | 8 | Register read data |
| rd_n_o | output | 1 | Active-low read strobe |
| cap_o | output | 1 | Data-capture pulse |
| done_o | output | 1 | End-of-cycle pulse |

## Verification
The bench builds the block with its default parameters: eight areas, a two-state short cycle and a three-state long cycle. With these values, both strobe lengths and both release points can be reached from one 8-bit register. A vector table walks every area, with both bit values and both cycle lengths. Directed tests cover register changes in the middle of a cycle, requests that arrive while a cycle runs, and back-to-back cycles that chain on the done tick.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
   // Configuration latched at the start of one read cycle
   typedef struct packed {
      logic early;   // release the strobe one half-state sooner
      logic long_c;  // use the long cycle length
   } rsg_cfg_t;
endpackage

// File: rtl/rsg_ctrl_reg.sv
module rsg_ctrl_reg #(
   parameter int NUM_AREAS = 8,
   localparam int AW = $clog2(NUM_AREAS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic [NUM_AREAS-1:0] wdata_i,
   input  logic [AW-1:0]        sel_i,
   output logic [NUM_AREAS-1:0] bits_o,
   output logic                 sel_bit_o
);
   generate
      if (NUM_AREAS < 2) begin : g_bad
         $error("rsg_ctrl_reg: NUM_AREAS must be at least 2");
      end
      // One flop per area bit
      for (genvar n = 0; n < NUM_AREAS; n++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    bits_o[n] <= 1'b0;
            else if (we_i) bits_o[n] <= wdata_i[n];
         end
      end
   endgenerate

   assign sel_bit_o = bits_o[sel_i];

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(bits_o));
endmodule

// File: rtl/rsg_seq.sv
module rsg_seq
   import rsg_pkg::*;
#(
   parameter int SHORT_STATES = 2,
   parameter int LONG_STATES  = 3,
   localparam int CNT_W = $clog2(2*LONG_STATES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             long_i,
   input  logic             early_i,
   output logic             busy_o,
   output logic [CNT_W-1:0] cnt_o,
   output rsg_cfg_t         cfg_o,
   output logic             last_o
);
   localparam logic [CNT_W-1:0] LAST_S = CNT_W'(2*SHORT_STATES-1);
   localparam logic [CNT_W-1:0] LAST_L = CNT_W'(2*LONG_STATES-1);

   generate
      if (SHORT_STATES < 2 || LONG_STATES < SHORT_STATES) begin : g_bad
         $error("rsg_seq: need 2 <= SHORT_STATES <= LONG_STATES");
      end
   endgenerate

   logic start;
   assign last_o = busy_o && (cnt_o == (cfg_o.long_c ? LAST_L : LAST_S));
   assign start  = req_i && (!busy_o || last_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_o  <= '0;
         cfg_o  <= '0;
      end else if (start) begin
         busy_o       <= 1'b1;
         cnt_o        <= '0;
         cfg_o.early  <= early_i;
         cfg_o.long_c <= long_i;
      end else if (last_o) begin
         busy_o <= 1'b0;
         cnt_o  <= '0;
      end else if (busy_o) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end

   // R10
   run_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !last_o) |=> (busy_o && cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/rsg_strobe_dec.sv
module rsg_strobe_dec
   import rsg_pkg::*;
#(
   parameter int SHORT_STATES = 2,
   parameter int LONG_STATES  = 3,
   localparam int CNT_W = $clog2(2*LONG_STATES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  rsg_cfg_t         cfg_i,
   output logic             rd_n_o,
   output logic             cap_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] LAST_S = CNT_W'(2*SHORT_STATES-1);
   localparam logic [CNT_W-1:0] LAST_L = CNT_W'(2*LONG_STATES-1);

   logic [CNT_W-1:0] last_tick, rel_tick;
   assign last_tick = cfg_i.long_c ? LAST_L : LAST_S;
   assign rel_tick  = last_tick - CNT_W'(cfg_i.early);

   assign rd_n_o = !(busy_i && cnt_i >= CNT_W'(1) && cnt_i <= rel_tick);
   assign cap_o  = busy_i && (cnt_i == rel_tick);
   assign done_o = busy_i && (cnt_i == last_tick);

   // R6
   cap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_o |=> rd_n_o);
   // R7
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> rd_n_o);
   // R5
   early_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_o && !done_o) |=> done_o);
endmodule

// File: rtl/rsg_read_strobe.sv
module rsg_read_strobe
   import rsg_pkg::*;
#(
   parameter int NUM_AREAS    = 8,
   parameter int SHORT_STATES = 2,
   parameter int LONG_STATES  = 3,
   localparam int AW    = $clog2(NUM_AREAS),
   localparam int CNT_W = $clog2(2*LONG_STATES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic [AW-1:0]        area_i,
   input  logic                 three_state_i,
   input  logic                 reg_we_i,
   input  logic [NUM_AREAS-1:0] reg_wdata_i,
   output logic [NUM_AREAS-1:0] reg_rdata_o,
   output logic                 rd_n_o,
   output logic                 cap_o,
   output logic                 done_o
);
   logic             sel_bit, busy, last;
   logic [CNT_W-1:0] cnt;
   rsg_cfg_t         cfg;

   rsg_ctrl_reg #(.NUM_AREAS(NUM_AREAS)) u_reg (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
      .sel_i(area_i), .bits_o(reg_rdata_o), .sel_bit_o(sel_bit));

   rsg_seq #(.SHORT_STATES(SHORT_STATES), .LONG_STATES(LONG_STATES)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .long_i(three_state_i),
      .early_i(sel_bit), .busy_o(busy), .cnt_o(cnt), .cfg_o(cfg),
      .last_o(last));

   rsg_strobe_dec #(.SHORT_STATES(SHORT_STATES), .LONG_STATES(LONG_STATES)) u_dec (
      .clk(clk), .rst_n(rst_n), .busy_i(busy), .cnt_i(cnt), .cfg_i(cfg),
      .rd_n_o(rd_n_o), .cap_o(cap_o), .done_o(done_o));

   // R7
   last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> done_o);
   // R3
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> rd_n_o);
endmodule

// File: tb/tb_rsg_read_strobe.sv
`timescale 1ns/1ps
module tb_rsg_read_strobe;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_i = 1'b0;
   logic [2:0] area_i = '0;
   logic       three_state_i = 1'b0;
   logic       reg_we_i = 1'b0;
   logic [7:0] reg_wdata_i = '0;
   logic [7:0] reg_rdata_o;
   logic       rd_n_o, cap_o, done_o;
   int         errors = 0;
   int         checks = 0;

   always #2 clk = ~clk;

   rsg_read_strobe dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .area_i(area_i),
      .three_state_i(three_state_i), .reg_we_i(reg_we_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .rd_n_o(rd_n_o), .cap_o(cap_o), .done_o(done_o));

   // vector: {area, three_state, register value}
   localparam int NV = 10;
   localparam logic [11:0] VEC [NV] = '{
      {3'd0, 1'b1, 8'h00}, {3'd0, 1'b1, 8'h01}, {3'd1, 1'b0, 8'h02},
      {3'd2, 1'b0, 8'hFB}, {3'd3, 1'b1, 8'h08}, {3'd4, 1'b0, 8'h10},
      {3'd5, 1'b1, 8'hDF}, {3'd6, 1'b0, 8'h40}, {3'd7, 1'b1, 8'h80},
      {3'd7, 1'b0, 8'h7F}};

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] v);
      reg_we_i = 1'b1; reg_wdata_i = v;
      @(negedge clk);
      reg_we_i = 1'b0;
   endtask

   // Check one sample point of a cycle at tick i
   task automatic chk_tick(input int i, input int n, input logic early, input string tag);
      int rel = 2*n - 1 - int'(early);
      logic exp_rd = !(i >= 1 && i <= rel);
      chk(rd_n_o == exp_rd, {tag, " R3/R4/R5 rd_n"}, rd_n_o, exp_rd);
      chk(cap_o == (i == rel), {tag, " R6 cap"}, cap_o, int'(i == rel));
      chk(done_o == (i == 2*n-1), {tag, " R7 done"}, done_o, int'(i == 2*n-1));
   endtask

   task automatic run_cycle(input logic [2:0] a, input logic three, input logic early, input string tag);
      int n = three ? 3 : 2;
      req_i = 1'b1; area_i = a; three_state_i = three;
      @(negedge clk);
      req_i = 1'b0;
      for (int i = 0; i <= 2*n; i++) begin
         chk_tick(i, n, early, tag);
         @(negedge clk);
      end
   endtask

   initial begin
      #100000;
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(reg_rdata_o == 8'h00, "R1 rdata", reg_rdata_o, 0);
      chk(rd_n_o == 1'b1, "R1 rd_n", rd_n_o, 1);
      chk(!cap_o && !done_o, "R1 pulses", {cap_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R2, R4, R5, R8
      for (int v = 0; v < NV; v++) begin
         logic [2:0] a = VEC[v][11:9];
         logic       t = VEC[v][8];
         logic [7:0] r = VEC[v][7:0];
         wr_reg(r);
         chk(reg_rdata_o == r, "R2 readback", reg_rdata_o, r);
         run_cycle(a, t, r[a], t ? "R8 long" : "R8 short");
      end

      // R9: register and area change mid-cycle do not alter the cycle
      wr_reg(8'h00);
      req_i = 1'b1; area_i = 3'd3; three_state_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      for (int i = 0; i <= 6; i++) begin
         if (i == 2) begin
            reg_we_i = 1'b1; reg_wdata_i = 8'hFF; area_i = 3'd5; three_state_i = 1'b0;
         end else begin
            reg_we_i = 1'b0;
         end
         chk_tick(i, 3, 1'b0, "R9 latch");
         @(negedge clk);
      end
      chk(reg_rdata_o == 8'hFF, "R9 write landed", reg_rdata_o, 8'hFF);

      // R10: request during a cycle is ignored
      req_i = 1'b1; area_i = 3'd1; three_state_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      for (int i = 0; i <= 8; i++) begin
         req_i = (i == 2);
         if (i <= 6) chk_tick(i, 3, 1'b1, "R10 busy");
         else chk(rd_n_o && !done_o, "R10 idle after", rd_n_o, 1);
         @(negedge clk);
      end
      req_i = 1'b0;

      // R11: back-to-back, request held through done
      wr_reg(8'h00);
      req_i = 1'b1; area_i = 3'd2; three_state_i = 1'b0;
      @(negedge clk);
      for (int i = 0; i <= 3; i++) begin
         chk_tick(i, 2, 1'b0, "R11 first");
         @(negedge clk);
      end
      req_i = 1'b0;
      for (int i = 0; i <= 4; i++) begin
         chk_tick(i, 2, 1'b0, "R11 chained");
         @(negedge clk);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule